// File: doc/BRIEF.md
# Logic Analyzer Trigger-Capture Controller

This block records a wide parallel probe bus into an on-chip sample memory, one word per sample strobe. The strobe comes either from an internal clock divider or from an external clock pin. The external pin is brought into the system clock domain by a two-flop synchronizer, and each of its rising edges yields one strobe. An edge trigger watches the probe bus. Each bit has its own participation enable and its own slope choice, and the trigger fires when any participating bit shows its chosen transition between two consecutive strobes.

A host pulses an arm input to start a run. The run uses one of three recording policies, latched at arm. In the first, the block records nothing until the trigger and then fills the whole memory. In the second, it records continuously as a ring and freezes on the trigger. In the third, it records as a ring and then adds half a memory of samples after the trigger, so the event sits in the middle of the record. Once the run is finished, the host reads any memory word by address and reads the pointer value that the trigger sample was written to.

Top module: `la_trig_capture`

## Requirements
- R1: After reset, state_o is 0 (idle), trig_addr_o is 0, rd_valid_o is 0 and rd_data_o is 0.
- R2: With src_sel_i = 0 a strobe occurs once every INT_DIV clocks. With src_sel_i = 1 a strobe occurs only once per rising edge of ext_clk_i, after a two-flop synchronizer, so no strobe occurs while ext_clk_i is held still.
- R3: A trigger needs a strobe, a previous sample taken since arm, and at least one bit with trig_en_i = 1 whose value moved in the direction that trig_fall_i selects for it (1 = high to low, 0 = low to high). Bits with trig_en_i = 0 never trigger.
- R4: Mode 0 (mode 3 is treated the same): nothing is written before the trigger. The trigger sample is written at address 0, followed by DEPTH-1 further samples at rising addresses, and then the state becomes done.
- R5: Mode 1: every strobe writes the sample at the write pointer, which wraps from DEPTH-1 to 0. The trigger sample is the last one written, and the state becomes done on that strobe.
- R6: Mode 2: every strobe writes the sample as in mode 1 until the trigger. The trigger sample is written, followed by exactly DEPTH/2 further samples, and then the state becomes done.
- R7: trig_addr_o gives the address at which the trigger sample was written. It is cleared to 0 when an arm is accepted.
- R8: state_o encodes 0 = idle, 1 = armed, 2 = post-trigger and 3 = done. An arm pulse in idle or done moves the state to armed and clears the write pointer. An arm pulse is ignored in armed and in post-trigger. Done holds until the next arm.
- R9: Only one trigger is taken per arm. Edges seen in post-trigger or in done leave the state and trig_addr_o unchanged.
- R10: A rd_en_i in idle or done returns the memory word at rd_addr_i on rd_data_o one clock later, with rd_valid_o = 1. In armed or post-trigger a rd_en_i is ignored and rd_valid_o stays 0.
- R11: mode_i is sampled only when an arm is accepted. Later changes to it do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External sample clock, asynchronous |
| src_sel_i | input | 1 | Strobe source: 0 internal divider, 1 external clock |
| probe_i | input | SAMPLE_W | Probe bus being sampled |
| arm_i | input | 1 | One-cycle arm pulse |
| mode_i | input | 2 | Recording policy: 0 start, 1 stop, 2 centre, 3 start |
| trig_en_i | input | SAMPLE_W | Per-bit trigger participation |
| trig_fall_i | input | SAMPLE_W | Per-bit slope, 1 selects a falling edge |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | SAMPLE_W | Read data, one clock after the request |
| rd_valid_o | output | 1 | rd_data_o holds a fresh word |
| state_o | output | 2 | Run state |
| trig_addr_o | output | AW | Address of the trigger sample |

## Verification
The properties assume that arm_i is a single-cycle pulse. They also assume that src_sel_i does not change during a run and that ext_clk_i stays at each level for at least two system clocks, so every rising edge gives a separate strobe. The bench drives arm through a one-cycle pulse task. It changes the source only while the unit is idle or done, and it toggles the external clock every four system clocks. The masks are changed only between runs or on the one enabled bit that forms the intended edge.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } la_state_e;

    typedef enum logic [1:0] {
        MD_START  = 2'd0,
        MD_STOP   = 2'd1,
        MD_CENTRE = 2'd2,
        MD_START2 = 2'd3
    } la_mode_e;

endpackage

// File: rtl/la_strobe_gen.sv
module la_strobe_gen #(
    parameter int INT_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext_i,
    input  logic ext_clk_i,
    output logic strobe_o
);
    localparam int CW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(INT_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [2:0]    sync;
    } gen_t;

    gen_t d, q;
    logic int_strobe;
    logic ext_strobe;

    always_comb begin
        d          = q;
        d.sync     = {q.sync[1:0], ext_clk_i};
        d.cnt      = (q.cnt == CNT_LAST) ? '0 : q.cnt + 1'b1;
        int_strobe = (q.cnt == CNT_LAST);
        ext_strobe = q.sync[1] & ~q.sync[2];
        strobe_o   = src_ext_i ? ext_strobe : int_strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/la_edge_trig.sv
module la_edge_trig #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic         clear_i,
    input  logic [W-1:0] sample_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] fall_i,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         valid;
    } edge_t;

    edge_t d, q;
    logic [W-1:0] bit_hit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (fall_i[i]) begin
                bit_hit[i] = en_i[i] & q.prev[i] & ~sample_i[i];
            end else begin
                bit_hit[i] = en_i[i] & ~q.prev[i] & sample_i[i];
            end
        end
    end

    always_comb begin
        d = q;
        if (strobe_i) begin
            d.prev  = sample_i;
            d.valid = 1'b1;
        end
        if (clear_i) begin
            d.valid = 1'b0;
        end
        hit_o = strobe_i & q.valid & (|bit_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
    import la_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          hit_i,
    input  logic          arm_i,
    input  logic [1:0]    mode_i,
    output la_state_e     state_o,
    output la_mode_e      mode_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] trig_addr_o,
    output logic          clear_o,
    output logic          rd_ok_o
);
    localparam logic [AW-1:0] POST_HALF = AW'(DEPTH / 2);
    localparam logic [AW-1:0] POST_FULL = AW'(DEPTH - 1);

    typedef struct packed {
        la_state_e     st;
        la_mode_e      mode;
        logic [AW-1:0] wp;
        logic [AW-1:0] trig;
        logic [AW-1:0] rem;
    } ctrl_t;

    ctrl_t d, q;
    logic  ring_mode;

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        clear_o   = 1'b0;
        ring_mode = (q.mode == MD_STOP) || (q.mode == MD_CENTRE);
        unique case (q.st)
            ST_IDLE, ST_DONE: begin
                if (arm_i) begin
                    d.st    = ST_ARMED;
                    d.wp    = '0;
                    d.trig  = '0;
                    d.mode  = la_mode_e'(mode_i);
                    clear_o = 1'b1;
                end
            end
            ST_ARMED: begin
                if (strobe_i) begin
                    if (ring_mode) begin
                        wr_en_o = 1'b1;
                        d.wp    = q.wp + 1'b1;
                        if (hit_i) begin
                            d.trig = q.wp;
                            if (q.mode == MD_STOP) begin
                                d.st = ST_DONE;
                            end else begin
                                d.st  = ST_POST;
                                d.rem = POST_HALF;
                            end
                        end
                    end else if (hit_i) begin
                        wr_en_o = 1'b1;
                        d.wp    = q.wp + 1'b1;
                        d.trig  = q.wp;
                        d.rem   = POST_FULL;
                        d.st    = ST_POST;
                    end
                end
            end
            ST_POST: begin
                if (strobe_i) begin
                    wr_en_o = 1'b1;
                    d.wp    = q.wp + 1'b1;
                    d.rem   = q.rem - 1'b1;
                    if (q.rem == AW'(1)) begin
                        d.st = ST_DONE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        wr_addr_o   = q.wp;
        trig_addr_o = q.trig;
        state_o     = q.st;
        mode_o      = q.mode;
        rd_ok_o     = (q.st == ST_IDLE) || (q.st == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, mode: MD_START, wp: '0, trig: '0, rem: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
    parameter int W     = 40,
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o,
    output logic          rd_valid_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         valid;
    } rd_t;

    logic [W-1:0] mem [DEPTH];
    rd_t d, q;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    always_comb begin
        d       = q;
        d.valid = rd_en_i;
        if (rd_en_i) begin
            d.data = mem[rd_addr_i];
        end
        rd_data_o  = q.data;
        rd_valid_o = q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/la_trig_capture.sv
module la_trig_capture
    import la_pkg::*;
#(
    parameter int SAMPLE_W = 40,
    parameter int DEPTH    = 2048,
    parameter int INT_DIV  = 2,
    parameter int AW       = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_clk_i,
    input  logic                src_sel_i,
    input  logic [SAMPLE_W-1:0] probe_i,
    input  logic                arm_i,
    input  logic [1:0]          mode_i,
    input  logic [SAMPLE_W-1:0] trig_en_i,
    input  logic [SAMPLE_W-1:0] trig_fall_i,
    input  logic                rd_en_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic [SAMPLE_W-1:0] rd_data_o,
    output logic                rd_valid_o,
    output logic [1:0]          state_o,
    output logic [AW-1:0]       trig_addr_o
);
    logic          strobe;
    logic          hit;
    logic          clr_edge;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_ok;
    la_state_e     cap_state;
    la_mode_e      cap_mode;

    la_strobe_gen #(.INT_DIV(INT_DIV)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_ext_i (src_sel_i),
        .ext_clk_i (ext_clk_i),
        .strobe_o  (strobe)
    );

    la_edge_trig #(.W(SAMPLE_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe),
        .clear_i  (clr_edge),
        .sample_i (probe_i),
        .en_i     (trig_en_i),
        .fall_i   (trig_fall_i),
        .hit_o    (hit)
    );

    la_capture_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe),
        .hit_i       (hit),
        .arm_i       (arm_i),
        .mode_i      (mode_i),
        .state_o     (cap_state),
        .mode_o      (cap_mode),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .trig_addr_o (trig_addr_o),
        .clear_o     (clr_edge),
        .rd_ok_o     (rd_ok)
    );

    la_sample_ram #(.W(SAMPLE_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (probe_i),
        .rd_en_i    (rd_en_i & rd_ok),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    assign state_o = cap_state;

endmodule

// File: rtl/la_trig_capture_chk.sv
module la_trig_capture_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic          rd_en_i,
    input logic          src_sel_i,
    input logic          strobe,
    input logic          hit,
    input logic [1:0]    mode_q,
    input logic [1:0]    state_o,
    input logic [AW-1:0] trig_addr_o,
    input logic          rd_valid_o
);
    logic at_rest;
    logic busy;
    assign at_rest = (state_o == 2'd0) || (state_o == 2'd3);
    assign busy    = (state_o == 2'd1) || (state_o == 2'd2);

    AST_ARM_FROM_REST: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && at_rest |=> state_o == 2'd1); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd3 && !arm_i |=> state_o == 2'd3); // R8
    AST_BUSY_ARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd2 && arm_i && !strobe |=> state_o == 2'd2); // R8
    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && busy |=> !rd_valid_o); // R10
    AST_RD_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && at_rest |=> rd_valid_o); // R10
    AST_TRIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) || (state_o == 2'd3 && !arm_i) |=> $stable(trig_addr_o)); // R9
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd1 && mode_q == 2'd1 && hit |=> state_o == 2'd3); // R5
    AST_START_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd1 && mode_q == 2'd0 && !hit |=> state_o == 2'd1); // R4
    AST_EXT_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_i && strobe |=> !(src_sel_i && strobe)); // R2

endmodule

bind la_trig_capture la_trig_capture_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .rd_en_i     (rd_en_i),
    .src_sel_i   (src_sel_i),
    .strobe      (strobe),
    .hit         (hit),
    .mode_q      (cap_mode),
    .state_o     (state_o),
    .trig_addr_o (trig_addr_o),
    .rd_valid_o  (rd_valid_o)
);

// File: tb/la_trig_capture_test.sv
module la_trig_capture_test;
    localparam int W   = 40;
    localparam int D   = 2048;
    localparam int DIV = 2;
    localparam int AW  = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_clk = 1'b0;
    logic          ext_run = 1'b1;
    logic          src_sel = 1'b0;
    logic          arm = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [W-1:0]  probe = '0;
    logic [W-1:0]  en = '0;
    logic [W-1:0]  fall = '0;
    logic [W-1:0]  ctrl_bits = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic [1:0]    state;
    logic [AW-1:0] trig_addr;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_req = "R8";

    always #4 clk = ~clk;

    la_trig_capture #(.SAMPLE_W(W), .DEPTH(D), .INT_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .src_sel_i(src_sel),
        .probe_i(probe), .arm_i(arm), .mode_i(mode), .trig_en_i(en),
        .trig_fall_i(fall), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .state_o(state),
        .trig_addr_o(trig_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int           m_st, m_mode, m_wp, m_trig, m_rem, m_div;
    bit           m_e1, m_e2, m_e3, m_pv, m_rv;
    logic [W-1:0] m_prev, m_rd;
    logic [W-1:0] m_mem [D];

    always @(posedge clk) begin : model
        bit           str, hit, arm_ok;
        logic [W-1:0] moved;
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_wp = 0; m_trig = 0; m_rem = 0; m_div = 0;
            m_e1 = 0; m_e2 = 0; m_e3 = 0; m_pv = 0; m_rv = 0;
            m_prev = '0; m_rd = '0;
        end else begin
            str = src_sel ? (m_e2 && !m_e3) : (m_div == DIV - 1);
            m_div = (m_div + 1) % DIV;
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
            moved = (fall & m_prev & ~probe) | (~fall & ~m_prev & probe);
            hit = str && m_pv && ((moved & en) != '0);
            arm_ok = arm && (m_st == 0 || m_st == 3);
            m_rv = rd_en && (m_st == 0 || m_st == 3);
            if (m_rv) m_rd = m_mem[rd_addr];
            if (arm_ok) begin
                m_st = 1; m_wp = 0; m_trig = 0; m_mode = int'(mode);
            end else if (m_st == 1 && str) begin
                if (m_mode == 1 || m_mode == 2) begin
                    m_mem[m_wp] = probe;
                    if (hit) begin
                        m_trig = m_wp;
                        if (m_mode == 1) m_st = 3;
                        else begin m_st = 2; m_rem = D / 2; end
                    end
                    m_wp = (m_wp + 1) % D;
                end else if (hit) begin
                    m_mem[m_wp] = probe;
                    m_trig = m_wp;
                    m_wp = (m_wp + 1) % D;
                    m_rem = D - 1;
                    m_st = 2;
                end
            end else if (m_st == 2 && str) begin
                m_mem[m_wp] = probe;
                m_wp = (m_wp + 1) % D;
                m_rem--;
                if (m_rem == 0) m_st = 3;
            end
            if (str) begin m_prev = probe; m_pv = 1; end
            if (arm_ok) m_pv = 0;
        end
    end

    // every-cycle comparison and stimulus, away from the active edge
    int ext_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(state === 2'(m_st), {cur_req, "/R8 state"}, 64'(state), 64'(m_st));
            check(trig_addr === AW'(m_trig), {cur_req, "/R7 trig_addr"}, 64'(trig_addr), 64'(m_trig));
            check(rd_valid === m_rv, {cur_req, "/R10 rd_valid"}, 64'(rd_valid), 64'(m_rv));
            if (m_rv) check(rd_data === m_rd, {cur_req, "/R10 rd_data"}, 64'(rd_data), 64'(m_rd));
        end
        probe = ({$urandom, $urandom} & ~en) | (ctrl_bits & en);
        if (ext_run) begin
            ext_cnt++;
            if (ext_cnt == 4) begin ext_cnt = 0; ext_clk = ~ext_clk; end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic wait_st(input int s, input int lim);
        for (int i = 0; i < lim && state !== 2'(s); i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [AW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(state === 2'd0, "R1 state", 64'(state), 0);
        check(trig_addr === '0, "R1 trig_addr", 64'(trig_addr), 0);
        check(rd_valid === 1'b0 && rd_data === '0, "R1 read port", 64'(rd_data), 0);

        // start mode, internal strobe, rising edge on bit 5
        cur_req = "R4";
        en = W'(1) << 5; fall = '0; ctrl_bits = '0; mode = 2'd0; src_sel = 1'b0;
        pulse_arm();
        check(state === 2'd1, "R8 arm from idle", 64'(state), 1);
        step(40);
        check(state === 2'd1, "R3 disabled bits ignored", 64'(state), 1);
        @(negedge clk); rd_en = 1'b1; rd_addr = '0;
        @(negedge clk); rd_en = 1'b0;
        check(rd_valid === 1'b0, "R10 read while armed", 64'(rd_valid), 0);
        ctrl_bits = W'(1) << 5;
        wait_st(2, 10);
        check(state === 2'd2, "R4 trigger enters post", 64'(state), 2);
        pulse_arm();
        cur_req = "R9";
        ctrl_bits = '0; step(6); ctrl_bits = W'(1) << 5; step(6);
        check(state === 2'd2 && trig_addr === '0, "R9 later edges ignored", 64'(state), 2);
        wait_st(3, 6000);
        check(state === 2'd3, "R4 done after full depth", 64'(state), 3);
        check(trig_addr === '0, "R7 start trigger at 0", 64'(trig_addr), 0);
        cur_req = "R10";
        for (int i = 0; i < D; i++) begin
            @(negedge clk); rd_en = 1'b1; rd_addr = AW'(i);
        end
        @(negedge clk); rd_en = 1'b1; rd_addr = '0;
        @(negedge clk); rd_en = 1'b0;
        check(rd_data[5] === 1'b1, "R4 trigger sample at address 0", 64'(rd_data[5]), 1);

        // stop mode, external strobe, falling edge on bit 0, ring wraps
        cur_req = "R5";
        ctrl_bits = '1; en = W'(1); fall = W'(1); mode = 2'd1; src_sel = 1'b1;
        step(4);
        pulse_arm();
        step(17000);
        check(state === 2'd1, "R5 ring keeps running", 64'(state), 1);
        cur_req = "R2";
        ext_run = 1'b0; ext_clk = 1'b0; step(8);
        ctrl_bits = '0; step(20);
        check(state === 2'd1, "R2 no strobe while external clock still", 64'(state), 1);
        ctrl_bits = '1; step(20);
        ext_run = 1'b1;
        cur_req = "R5";
        step(20);
        ctrl_bits = '0;
        wait_st(3, 40);
        check(state === 2'd3, "R5 halts on trigger", 64'(state), 3);
        check(trig_addr === AW'(m_trig) && m_trig != 0, "R5 wrapped trigger address", 64'(trig_addr), 64'(m_trig));
        held = trig_addr;
        cur_req = "R9";
        ctrl_bits = '1; step(20); ctrl_bits = '0; step(20);
        check(state === 2'd3 && trig_addr === held, "R9 done ignores edges", 64'(trig_addr), 64'(held));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rd_en = 1'b1; rd_addr = held - AW'(i);
        end
        @(negedge clk); rd_en = 1'b0;

        // centre mode, internal strobe, rising edge on bit 39, mode latched
        cur_req = "R6";
        src_sel = 1'b0; step(4);
        en = W'(1) << (W - 1); fall = '0; ctrl_bits = '0; mode = 2'd2;
        pulse_arm();
        mode = 2'd1;
        step(100);
        ctrl_bits = W'(1) << (W - 1);
        wait_st(2, 10);
        check(state === 2'd2, "R11 latched centre mode", 64'(state), 2);
        held = trig_addr;
        wait_st(3, 3000);
        check(state === 2'd3, "R6 done after half depth", 64'(state), 3);
        check(trig_addr === held && m_wp == (int'(held) + D / 2 + 1) % D, "R6 half-depth record", 64'(m_wp), 64'((int'(held) + D / 2 + 1) % D));
        cur_req = "R10";
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rd_en = 1'b1; rd_addr = held + AW'(i);
        end
        @(negedge clk); rd_en = 1'b0;
        step(2);
        summary();
        $finish;
    end

endmodule